// File: doc/BRIEF.md
# Channel-List Conversion Sequencer

This block sits between a 16-bit register bus and a 12-bit sampling converter. Software loads a queue of per-conversion settings: an input channel, a gain code, a polarity choice and single-ended or differential mode. It then picks a trigger mode. Each accepted trigger takes the oldest queued setting and presents it to the converter with a request. The request stays up until the converter answers with a done pulse and a two's-complement sample. The sample is stored in a result queue in offset-binary form.

In software mode a bus read of the start address is the trigger. In external mode the trigger is a rising edge on a trigger input. A status word reports how full both queues are and whether a conversion is in flight. An interrupt can be raised when the result queue reaches half full, and any write to the status address clears it. Clearing a queue's enable bit empties that queue and keeps it empty.

All reads return their data on `bus_rdata` in the clock cycle after the read. Addresses are byte offsets.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset the status word reads 0x0004 (result queue empty, nothing else set), and `irq` and `conv_req` are low.
- R2: A setting written at offset 0x10 is decoded as channel in bits 3:0, gain code in bits 5:4, unipolar in bit 6 and differential in bit 7. These fields appear on `conv_chan`, `conv_gain`, `conv_unipolar` and `conv_diff` while `conv_req` is high.
- R3: With the mode field (control word 1 at offset 0x0, bits 1:0) set to 1, each read of offset 0x0 takes one setting from the head of the list and raises one request. A read made while a conversion is active, or while the list is empty, starts nothing.
- R4: Mode codes 0 (off) and 2 (scan) start nothing on a start read or on the trigger input. Mode 3 starts a conversion on each rising edge of `ext_trig`, and a start read does nothing in that mode.
- R5: A read of offset 0x10 pops the oldest result, in first-in first-out order. Bits 11:0 hold the converter's sample with bit 11 inverted, and bits 15:12 read zero.
- R6: A read of offset 0x10 while the result queue is empty returns the value the previous such read returned, and leaves the queue empty.
- R7: Status (read at offset 0x4) has these bits: 0 conversion active, 1 list full (16 settings), 2 result queue empty, 3 result queue holding 8 or more, 4 result queue full (16 results), 8 half-full interrupt pending. All other bits read zero.
- R8: Control word 2 (offset 0x2) bit 10 enables the result queue and bit 9 enables the list. While an enable bit is low, its queue is empty and writes into it are dropped.
- R9: When the result queue rises to 8 or more entries and control word 1 bit 8 is set, the pending flag sets. `irq` equals pending AND control word 1 bit 15. Any write to offset 0x4 clears pending.
- R10: Writing control word 1 with mode bits 00 ends any active conversion at that clock edge: `conv_req` and the active flag go low, and a later `conv_done` stores nothing.
- R11: `conv_req`, once raised, stays high with unchanged setting fields until `conv_done` or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read |
| ext_trig | input | 1 | External trigger, rising edge used in mode 3 |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Channel of the current request |
| conv_gain | output | 2 | Gain code of the current request |
| conv_unipolar | output | 1 | Unipolar range for the current request |
| conv_diff | output | 1 | Differential input for the current request |
| conv_done | input | 1 | One-cycle pulse: sample ready |
| conv_result | input | 12 | Two's-complement sample, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the in-line properties check four things. A raised request holds steady until it is answered or aborted. An abort drops the request on the next edge. Neither queue ever counts beyond its depth, and a flushed queue reads empty. A pop on an empty result queue changes neither its count nor its output word. Only the scenarios can show the rest, because each depends on a whole sequence. These are the bit packing of a setting as seen by the converter, the offset-binary value and order of results, which trigger sources each mode honours, the exact fill levels where the status flags and the interrupt change, and that a start read during an active conversion leaves the list untouched.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int BUS_W    = 16;
  localparam int ADDR_W   = 5;
  localparam int SAMPLE_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL1  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL2  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h10;

  localparam int C1_HF_IE   = 8;
  localparam int C1_GLB_IE  = 15;
  localparam int C2_LIST_EN = 9;
  localparam int C2_RES_EN  = 10;

  localparam int ST_ACTIVE  = 0;
  localparam int ST_LFULL   = 1;
  localparam int ST_REMPTY  = 2;
  localparam int ST_RHALF   = 3;
  localparam int ST_RFULL   = 4;
  localparam int ST_HF_PEND = 8;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_SW   = 2'd1,
    TRIG_SCAN = 2'd2,
    TRIG_EXT  = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } list_entry_t;

  localparam int ENTRY_W = $bits(list_entry_t);

  typedef enum logic [1:0] {
    RSEL_ZERO,
    RSEL_STATUS,
    RSEL_RESULT
  } rd_sel_e;

endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && !flush && (cnt != FULL_CNT);
  assign do_pop  = pop  && !flush && (cnt != '0);
  assign count   = cnt;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      dout   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        dout   <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !flush && cnt == '0) |=> (cnt == '0 && $stable(dout)));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0));

endmodule

// File: rtl/adcseq_seq.sv
module adcseq_seq
  import adcseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic        list_empty,
  input  list_entry_t list_head,
  input  logic        abort,
  input  logic        conv_done,
  output logic        list_pop,
  output logic        res_push,
  output logic        conv_req,
  output list_entry_t conv_entry,
  output logic        active
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_REQ} seq_state_e;

  seq_state_e state;
  list_entry_t entry_q;
  logic req_q;

  assign list_pop   = trig && (state == S_IDLE) && !list_empty && !abort;
  assign res_push   = (state == S_REQ) && conv_done && !abort;
  assign conv_req   = req_q;
  assign conv_entry = entry_q;
  assign active     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      req_q   <= 1'b0;
      entry_q <= '0;
    end else if (abort) begin
      state <= S_IDLE;
      req_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (list_pop) state <= S_FETCH;
        S_FETCH: begin
          entry_q <= list_head;
          req_q   <= 1'b1;
          state   <= S_REQ;
        end
        S_REQ: if (conv_done) begin
          req_q <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done && !abort) |=> (conv_req && $stable(conv_entry)));

  // R10
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!conv_req && !active));

  // R3
  busy_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> !list_pop);

endmodule

// File: rtl/adcseq_irq.sv
module adcseq_irq (
  input  logic clk,
  input  logic rst,
  input  logic half_full,
  input  logic hf_en,
  input  logic glb_en,
  input  logic clr,
  output logic pending,
  output logic irq
);
  logic hf_q, set_ev, pend_d;

  assign set_ev = half_full && !hf_q && hf_en;
  // a new event wins over a clear in the same cycle
  assign pend_d = set_ev || (pending && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hf_q    <= 1'b0;
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      hf_q    <= half_full;
      pending <= pend_d;
      irq     <= pend_d && glb_en;
    end
  end

  // R9
  clr_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_ev) |=> !pending);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> pending);

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                ext_trig,
  output logic                conv_req,
  output logic [3:0]          conv_chan,
  output logic [1:0]          conv_gain,
  output logic                conv_unipolar,
  output logic                conv_diff,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_result,
  output logic                irq
);
  localparam int LCW = $clog2(LIST_DEPTH+1);
  localparam int RCW = $clog2(RES_DEPTH+1);
  localparam logic [LCW-1:0] LIST_FULL = LCW'(LIST_DEPTH);
  localparam logic [RCW-1:0] RES_FULL  = RCW'(RES_DEPTH);
  localparam logic [RCW-1:0] RES_HALF  = RCW'(RES_DEPTH/2);
  localparam logic [SAMPLE_W-1:0] SIGN_FLIP = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // register bus decode
  logic wr_c1, wr_c2, wr_st, wr_list, rd_start, rd_st, rd_res;
  assign wr_c1    = bus_en &&  bus_we && bus_addr == OFS_CTRL1;
  assign wr_c2    = bus_en &&  bus_we && bus_addr == OFS_CTRL2;
  assign wr_st    = bus_en &&  bus_we && bus_addr == OFS_STATUS;
  assign wr_list  = bus_en &&  bus_we && bus_addr == OFS_DATA;
  assign rd_start = bus_en && !bus_we && bus_addr == OFS_CTRL1;
  assign rd_st    = bus_en && !bus_we && bus_addr == OFS_STATUS;
  assign rd_res   = bus_en && !bus_we && bus_addr == OFS_DATA;

  trig_mode_e mode;
  logic hf_ie, glb_ie, list_en, res_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= TRIG_OFF;
      hf_ie   <= 1'b0;
      glb_ie  <= 1'b0;
      list_en <= 1'b0;
      res_en  <= 1'b0;
    end else begin
      if (wr_c1) begin
        mode   <= trig_mode_e'(bus_wdata[1:0]);
        hf_ie  <= bus_wdata[C1_HF_IE];
        glb_ie <= bus_wdata[C1_GLB_IE];
      end
      if (wr_c2) begin
        list_en <= bus_wdata[C2_LIST_EN];
        res_en  <= bus_wdata[C2_RES_EN];
      end
    end
  end

  // trigger sources
  logic ext_q, ext_rise, trig, abort;
  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_trig;
  end
  assign ext_rise = ext_trig && !ext_q;
  assign trig  = (mode == TRIG_SW  && rd_start) ||
                 (mode == TRIG_EXT && ext_rise);
  assign abort = wr_c1 && (bus_wdata[1:0] == 2'b00);

  // channel list
  logic [LCW-1:0]     list_cnt;
  logic [ENTRY_W-1:0] list_dout;
  logic               list_pop;

  adcseq_fifo #(.WIDTH(ENTRY_W), .DEPTH(LIST_DEPTH)) u_list (
    .clk   (clk),
    .rst   (rst),
    .flush (!list_en),
    .push  (wr_list),
    .din   (bus_wdata[ENTRY_W-1:0]),
    .pop   (list_pop),
    .dout  (list_dout),
    .count (list_cnt)
  );

  // sequencer
  list_entry_t cur_entry;
  logic res_push, active;

  adcseq_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .list_empty (list_cnt == '0),
    .list_head  (list_entry_t'(list_dout)),
    .abort      (abort),
    .conv_done  (conv_done),
    .list_pop   (list_pop),
    .res_push   (res_push),
    .conv_req   (conv_req),
    .conv_entry (cur_entry),
    .active     (active)
  );

  assign conv_chan     = cur_entry.chan;
  assign conv_gain     = cur_entry.gain;
  assign conv_unipolar = cur_entry.unipolar;
  assign conv_diff     = cur_entry.diff;

  // result queue
  logic [RCW-1:0]      res_cnt;
  logic [SAMPLE_W-1:0] res_dout;

  adcseq_fifo #(.WIDTH(SAMPLE_W), .DEPTH(RES_DEPTH)) u_res (
    .clk   (clk),
    .rst   (rst),
    .flush (!res_en),
    .push  (res_push),
    .din   (conv_result ^ SIGN_FLIP),
    .pop   (rd_res),
    .dout  (res_dout),
    .count (res_cnt)
  );

  // interrupt
  logic res_half, hf_pend;
  assign res_half = (res_cnt >= RES_HALF);

  adcseq_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .half_full (res_half),
    .hf_en     (hf_ie),
    .glb_en    (glb_ie),
    .clr       (wr_st),
    .pending   (hf_pend),
    .irq       (irq)
  );

  // status and read path
  logic [BUS_W-1:0] status_w, status_q;
  rd_sel_e rsel_q;

  always_comb begin
    status_w             = '0;
    status_w[ST_ACTIVE]  = active;
    status_w[ST_LFULL]   = (list_cnt == LIST_FULL);
    status_w[ST_REMPTY]  = (res_cnt == '0);
    status_w[ST_RHALF]   = res_half;
    status_w[ST_RFULL]   = (res_cnt == RES_FULL);
    status_w[ST_HF_PEND] = hf_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q   <= RSEL_ZERO;
      status_q <= '0;
    end else begin
      if (rd_st)       rsel_q <= RSEL_STATUS;
      else if (rd_res) rsel_q <= RSEL_RESULT;
      else             rsel_q <= RSEL_ZERO;
      if (rd_st) status_q <= status_w;
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_STATUS: bus_rdata = status_q;
      RSEL_RESULT: bus_rdata = {{(BUS_W-SAMPLE_W){1'b0}}, res_dout};
      default:     bus_rdata = '0;
    endcase
  end

  // R4
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_OFF || mode == TRIG_SCAN) |-> !list_pop);

  // R8
  list_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!list_en && $past(!list_en)) |-> (list_cnt == '0));

endmodule

// File: tb/adcseq_ctrl_bench.sv
module adcseq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic ext_trig = 0;
  logic conv_req, conv_unipolar, conv_diff, irq;
  logic [3:0] conv_chan;
  logic [1:0] conv_gain;
  logic conv_done = 0;
  logic [11:0] conv_result = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_ctrl u_adcseq_ctrl (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig(ext_trig), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_gain(conv_gain), .conv_unipolar(conv_unipolar),
    .conv_diff(conv_diff), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  logic [11:0] exp_q[$];
  int req_count = 0;
  logic hold = 0;
  int inject_req = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] sample_of(input logic [7:0] e);
    // chan, gain, unipolar, diff, then a fixed nibble
    return {e[3:0], e[5:4], e[6], e[7], 4'h3};
  endfunction

  // converter model: answers each request after LAT cycles
  initial begin
    int lat = 0;
    bit serving = 0;
    int inject_seen = 0;
    forever begin
      @(negedge clk);
      if (conv_done) conv_done = 0;
      if (inject_req != inject_seen) begin
        inject_seen = inject_req;
        conv_done = 1;
        conv_result = 12'h123;
      end else if (conv_req && !serving && !hold) begin
        serving = 1;
        lat = LAT;
        req_count++;
      end else if (serving) begin
        if (!conv_req) serving = 0;
        else if (lat == 0) begin
          conv_done = 1;
          conv_result = sample_of({conv_diff, conv_unipolar, conv_gain, conv_chan});
          serving = 0;
        end else lat--;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  // driver: pushes a setting and, when it will be converted, its expected result
  task automatic drive_entry(input logic [7:0] e, input bit will_convert);
    bus_write(5'h10, {8'h00, e});
    if (will_convert) exp_q.push_back(sample_of(e) ^ 12'h800);
  endtask

  // monitor: pops a result and compares with the scoreboard head
  task automatic monitor_result(input string tag);
    logic [15:0] d;
    logic [11:0] e;
    bus_read(5'h10, d);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 12'hxxx;
    chk(tag, d, {4'h0, e});
  endtask

  task automatic status(output logic [15:0] s);
    bus_read(5'h04, s);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, d, last;
    int rc;
    cyc(3);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 conv_req", conv_req, 0);
    status(s);
    chk("R1 status", s, 16'h0004);

    bus_write(5'h02, 16'h0600);
    bus_write(5'h00, 16'h0001);

    // R2 / R5 single conversion, packing checked through the converter
    drive_entry(8'hA5, 1);
    bus_read(5'h00, d);
    cyc(1);
    chk("R2 chan", conv_chan, 4'h5);
    chk("R2 gain", conv_gain, 2'd2);
    chk("R2 uni/diff", {conv_unipolar, conv_diff}, 2'b01);
    chk("R7 active", conv_req, 1);
    cyc(LAT + 4);
    status(s);
    chk("R7 one result", s, 16'h0000);
    monitor_result("R5 result A5");
    drive_entry(8'h4C, 1);
    bus_read(5'h00, d);
    cyc(LAT + 6);
    monitor_result("R5 result 4C");

    // R3 empty list: start read does nothing
    rc = req_count;
    bus_read(5'h00, d);
    cyc(LAT + 6);
    chk("R3 empty list", req_count, rc);

    // R3 start while active is ignored, list keeps second entry
    drive_entry(8'h13, 1);
    drive_entry(8'h37, 1);
    rc = req_count;
    bus_read(5'h00, d);
    bus_read(5'h00, d);
    cyc(LAT + 6);
    chk("R3 one request", req_count, rc + 1);
    bus_read(5'h00, d);
    cyc(LAT + 6);
    chk("R3 second request", req_count, rc + 2);
    monitor_result("R5 order 13");
    monitor_result("R5 order 37");

    // R4 modes 0 and 2 ignore both sources, mode 3 uses edges
    drive_entry(8'hF9, 1);
    rc = req_count;
    bus_write(5'h00, 16'h0002);
    bus_read(5'h00, d);
    ext_trig = 1; cyc(2); ext_trig = 0;
    cyc(LAT + 4);
    chk("R4 scan mode idle", req_count, rc);
    bus_write(5'h00, 16'h0000);
    bus_read(5'h00, d);
    ext_trig = 1; cyc(2); ext_trig = 0;
    cyc(LAT + 4);
    chk("R4 off mode idle", req_count, rc);
    bus_write(5'h00, 16'h0003);
    bus_read(5'h00, d);
    cyc(LAT + 4);
    chk("R4 ext mode ignores read", req_count, rc);
    ext_trig = 1; cyc(LAT + 6); ext_trig = 0;
    chk("R4 ext edge", req_count, rc + 1);
    monitor_result("R4 ext result F9");

    // R10 abort while waiting
    bus_write(5'h00, 16'h0001);
    hold = 1;
    drive_entry(8'h22, 0);
    bus_read(5'h00, d);
    cyc(3);
    chk("R10 req up", conv_req, 1);
    bus_write(5'h00, 16'h0000);
    chk("R10 req dropped", conv_req, 0);
    inject_req++;
    cyc(3);
    hold = 0;
    status(s);
    chk("R10 status after abort", s, 16'h0004);

    // R7 / R9 fill levels, list full, interrupt
    bus_write(5'h00, 16'h8101);
    for (int i = 0; i < 16; i++) drive_entry(8'(i * 7 + 16), 1);
    status(s);
    chk("R7 list full", s[1], 1);
    drive_entry(8'hEE, 0);
    for (int i = 0; i < 16; i++) begin
      bus_read(5'h00, d);
      cyc(LAT + 5);
      if (i == 6) begin
        status(s);
        chk("R7 seven results", s, 16'h0000);
        chk("R9 no irq at 7", irq, 0);
      end
      if (i == 7) begin
        status(s);
        chk("R7 R9 eight results", s, 16'h0108);
        chk("R9 irq at 8", irq, 1);
      end
    end
    status(s);
    chk("R7 result full", s, 16'h0118);
    rc = req_count;
    bus_read(5'h00, d);
    cyc(LAT + 5);
    chk("R7 extra list write dropped", req_count, rc);
    bus_write(5'h04, 16'h0000);
    cyc(1);
    chk("R9 cleared irq", irq, 0);
    status(s);
    chk("R9 cleared pending", s, 16'h0018);
    for (int i = 0; i < 16; i++) monitor_result("R5 burst");

    // R6 empty pop repeats last value
    bus_read(5'h10, last);
    bus_read(5'h10, d);
    chk("R6 repeat last", d, last);
    status(s);
    chk("R6 still empty", s, 16'h0004);

    // R8 disabling queues empties them and drops writes
    bus_write(5'h00, 16'h0001);
    drive_entry(8'h31, 1);
    bus_read(5'h00, d);
    cyc(LAT + 6);
    drive_entry(8'h32, 0);
    bus_write(5'h02, 16'h0000);
    drive_entry(8'h33, 0);
    bus_write(5'h02, 16'h0600);
    status(s);
    chk("R8 result flushed", s, 16'h0004);
    void'(exp_q.pop_front());
    rc = req_count;
    bus_read(5'h00, d);
    cyc(LAT + 6);
    chk("R8 list flushed", req_count, rc);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule